// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block walks a chain of command packets kept in a word-addressed memory of 2 MB. Each packet starts with one header word. The header holds the packet's payload size in words and the byte address of the packet that comes next. The walker reads each header and then reads the payload words that sit directly behind it. It hands those words to a downstream command consumer as a valid-qualified stream. After that it moves on to the next packet. The walk ends cleanly when a next-pointer has its terminator bit set.

A chain that is corrupt can point back into itself. To catch this, the walker keeps a checkpoint address. It compares every next-pointer against that checkpoint. The interval between checkpoint updates doubles each time it expires, so a loop of any length is caught after a bounded number of packets. While walking, the block adds up an estimate of the cycles the consumer will spend. When the walk finishes, it reports the total with a single-cycle done pulse and a loop-error flag.

Top module: `dma_chain_walker`

## Requirements
- R1: A start request takes a 24-bit byte address. If bit 23 of that address is set, the walk ends at once: no memory read, a total of 0, and a done pulse.
- R2: The memory is read at word index equal to the byte address bits [20:2]. Address bits 21 and 22 have no effect on which word is read.
- R3: A header word carries the payload length in bits [31:24] and the next byte address in bits [23:0]. The payload words are read from the memory words directly after the header, in ascending order. Each one appears exactly once on the output stream with `out_valid` high, in the same order.
- R4: A header with length 0 forwards no payload word, but its next address is still followed.
- R5: Every packet adds 10 to the total. A packet with a nonzero length adds a further 5 plus its length. The total reached at the end is held on `cycle_total` until the next start.
- R6: When a next address equals the checkpoint address, the walk stops with `loop_err` high. The payload of that last packet has already been forwarded.
- R7: The checkpoint address starts as the start address, and the checkpoint count starts at 32. Packets are numbered from 0. When the number of a packet equals the checkpoint count, the checkpoint address takes that packet's next address and the count doubles. A loop that does not pass through the start packet is still caught, and an acyclic chain longer than 32 packets is never flagged.
- R8: `done` is high for exactly one cycle at the end of each walk. `busy` is high from the cycle after an accepted start until that pulse. A start raised while busy is ignored.
- R9: `loop_err` keeps its value after the walk until the next accepted start, which clears it.
- R10: After reset, `busy`, `done`, `loop_err`, `out_valid` and `mem_rd_en` are low and `cycle_total` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 24 | Byte address of the first header |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| loop_err | output | 1 | Last walk stopped on a detected loop |
| cycle_total | output | 32 | Accumulated cycle estimate |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 19 | Memory word index |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| out_valid | output | 1 | Payload word valid |
| out_data | output | 32 | Payload word |

## Verification
Some internal faults show up at the ports as soon as the next packet is read. A wrong payload pointer or a miscounted length shows as a wrong or missing word on the stream, and a wrong next address shows as the wrong header being read. A wrong cost term shows only at the done pulse, as a total that differs from the hand-computed sum for that chain. A checkpoint that does not advance or does not double shows up only on long chains. Either the walk never ends and the bench times out, or an acyclic chain is flagged as a loop. For this reason the bench drives a cyclic chain of 35 packets and an acyclic one of 40.

// File: rtl/dma_chain_walker.sv
module dma_chain_walker #(
  parameter int ADDR_W    = 24,
  parameter int MEM_AW    = 19,
  parameter int LEN_W     = 8,
  parameter int DATA_W    = 32,
  parameter int COST_W    = 32,
  parameter int CNT_W     = 32,
  parameter int CKPT_INIT = 32,
  parameter int NODE_COST = 10,
  parameter int PAY_COST  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              done,
  output logic              loop_err,
  output logic [COST_W-1:0] cycle_total,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int BYTE_AW = MEM_AW + 2;
  localparam int END_BIT = ADDR_W - 1;
  localparam logic [COST_W-1:0] K_NODE = COST_W'(NODE_COST);
  localparam logic [COST_W-1:0] K_PAY  = COST_W'(PAY_COST);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_WAIT, S_PAY, S_CHK} st_t;

  st_t               st;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, ck_addr;
  logic [CNT_W-1:0]  ck_cnt, node_cnt;
  logic [MEM_AW-1:0] pay_ptr;
  logic [LEN_W-1:0]  pay_left;
  logic              pend_q;

  logic [LEN_W-1:0]  hdr_len;
  logic [ADDR_W-1:0] hdr_next;
  logic [COST_W-1:0] node_cost;

  assign hdr_len   = mem_rd_data[ADDR_W +: LEN_W];
  assign hdr_next  = mem_rd_data[ADDR_W-1:0];
  assign node_cost = (hdr_len != '0) ? (K_NODE + K_PAY + COST_W'(hdr_len)) : K_NODE;

  assign busy        = (st != S_IDLE);
  assign mem_rd_en   = (st == S_HDR) || (st == S_PAY);
  assign mem_rd_addr = (st == S_HDR) ? cur_addr[BYTE_AW-1:2] : pay_ptr;
  assign out_valid   = pend_q;
  assign out_data    = mem_rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cur_addr    <= '0;
      nxt_addr    <= '0;
      ck_addr     <= '0;
      ck_cnt      <= '0;
      node_cnt    <= '0;
      pay_ptr     <= '0;
      pay_left    <= '0;
      pend_q      <= 1'b0;
      done        <= 1'b0;
      loop_err    <= 1'b0;
      cycle_total <= '0;
    end else begin
      done   <= 1'b0;
      pend_q <= (st == S_PAY);
      case (st)
        S_IDLE: if (start) begin
          cur_addr    <= start_addr;
          ck_addr     <= start_addr;
          ck_cnt      <= CNT_W'(CKPT_INIT);
          node_cnt    <= '0;
          cycle_total <= '0;
          loop_err    <= 1'b0;
          if (start_addr[END_BIT]) done <= 1'b1;
          else                     st   <= S_HDR;
        end
        S_HDR: st <= S_WAIT;
        S_WAIT: begin
          nxt_addr    <= hdr_next;
          pay_ptr     <= cur_addr[BYTE_AW-1:2] + MEM_AW'(1);
          pay_left    <= hdr_len;
          cycle_total <= cycle_total + node_cost;
          st          <= (hdr_len == '0) ? S_CHK : S_PAY;
        end
        S_PAY: begin
          pay_ptr  <= pay_ptr + MEM_AW'(1);
          pay_left <= pay_left - LEN_W'(1);
          if (pay_left == LEN_W'(1)) st <= S_CHK;
        end
        S_CHK: begin
          if (nxt_addr == ck_addr) begin
            loop_err <= 1'b1;
            done     <= 1'b1;
            st       <= S_IDLE;
          end else begin
            if (node_cnt == ck_cnt) begin
              ck_addr <= nxt_addr;
              ck_cnt  <= ck_cnt << 1;
            end
            node_cnt <= node_cnt + CNT_W'(1);
            cur_addr <= nxt_addr;
            if (nxt_addr[END_BIT]) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= S_HDR;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_walker_chk.sv
module dma_chain_walker_chk #(
  parameter int COST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              loop_err,
  input logic [COST_W-1:0] cycle_total,
  input logic              mem_rd_en,
  input logic              out_valid
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_read_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_en);

  assert_out_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(mem_rd_en));

  assert_out_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  assert_loop_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(loop_err));

  assert_total_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cycle_total));

  assert_total_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (cycle_total >= $past(cycle_total)));

  assert_loop_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_err) |-> done);
endmodule

bind dma_chain_walker dma_chain_walker_chk #(.COST_W(COST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .loop_err(loop_err), .cycle_total(cycle_total), .mem_rd_en(mem_rd_en),
  .out_valid(out_valid)
);

// File: tb/tb_dma_chain_walker.sv
`timescale 1ns/1ps
module tb_dma_chain_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        busy, done, loop_err, mem_rd_en, out_valid;
  logic [31:0] cycle_total, mem_rd_data, out_data;
  logic [18:0] mem_rd_addr;

  always #2.5 clk = ~clk;

  dma_chain_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .loop_err(loop_err), .cycle_total(cycle_total),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  logic [31:0] mem [1024];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:0]];

  int checks = 0, failures = 0, cycles = 0;
  int wcnt = 0, bad_rd = 0;
  logic [31:0] wxor = '0, wfirst = '0, wlast = '0;

  always @(negedge clk) begin
    if (out_valid) begin
      if (wcnt == 0) wfirst = out_data;
      wlast = out_data;
      wxor  = wxor ^ out_data;
      wcnt  = wcnt + 1;
    end
    if (mem_rd_en && mem_rd_addr >= 19'd1024) bad_rd = bad_rd + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  typedef struct packed {
    logic [23:0] addr;
    logic [31:0] cost;
    logic        lp;
    logic [15:0] words;
    logic [31:0] wx;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{24'h000100, 32'd45,  1'b0, 16'd5,   32'hA0000001},
    '{24'h600100, 32'd45,  1'b0, 16'd5,   32'hA0000001},
    '{24'h800000, 32'd0,   1'b0, 16'd0,   32'h0},
    '{24'h000400, 32'd10,  1'b0, 16'd0,   32'h0},
    '{24'h0004B0, 32'd16,  1'b1, 16'd1,   32'hE0000001},
    '{24'h000640, 32'd350, 1'b1, 16'd0,   32'h0},
    '{24'h000800, 32'd270, 1'b0, 16'd255, 32'h11111111},
    '{24'h000C80, 32'd400, 1'b0, 16'd0,   32'h0}
  };
  localparam string VTAG [8] = '{"R3", "R2", "R1", "R4", "R6", "R7", "R3", "R7"};

  task automatic launch(input logic [23:0] a);
    wcnt = 0; wxor = '0; wfirst = '0; wlast = '0;
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R8 actual=no_done expected=done");
    end
  endtask

  initial begin
    bit ok;
    foreach (mem[i]) mem[i] = '0;
    mem[64]  = {8'd2, 24'h000200}; mem[65] = 32'hA0000001; mem[66] = 32'hA0000002;
    mem[128] = {8'd0, 24'h000300};
    mem[192] = {8'd3, 24'hFFFFFF};
    mem[193] = 32'hA0000003; mem[194] = 32'hA0000004; mem[195] = 32'hA0000005;
    mem[256] = {8'd0, 24'h800400};
    mem[300] = {8'd1, 24'h0004B0}; mem[301] = 32'hE0000001;
    mem[400] = {8'd0, 24'h000644};
    mem[401] = {8'd0, 24'h000648};
    mem[402] = {8'd0, 24'h000644};
    mem[512] = {8'd255, 24'h800000};
    for (int i = 513; i < 768; i++) mem[i] = 32'h11111111;
    for (int i = 0; i < 40; i++)
      mem[800+i] = (i == 39) ? {8'd0, 24'h800000} : {8'd0, 24'((801+i)*4)};

    repeat (3) @(negedge clk);
    chk("R10 busy", {31'd0, busy}, 32'd0);
    chk("R10 done", {31'd0, done}, 32'd0);
    chk("R10 loop", {31'd0, loop_err}, 32'd0);
    chk("R10 total", cycle_total, 32'd0);
    chk("R10 rd/out", {30'd0, mem_rd_en, out_valid}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      launch(VECS[v].addr);
      wait_done(ok);
      if (ok) begin
        chk({VTAG[v], " R5 total"}, cycle_total, VECS[v].cost);
        chk({VTAG[v], " R6 loop"}, {31'd0, loop_err}, {31'd0, VECS[v].lp});
        chk({VTAG[v], " R3 words"}, wcnt, {16'd0, VECS[v].words});
        chk({VTAG[v], " R3 xor"}, wxor, VECS[v].wx);
        @(negedge clk);
        chk("R8 done pulse", {30'd0, done, busy}, 32'd0);
      end
    end
    chk("R2 read index range", bad_rd, 0);

    launch(24'h000100);
    wait_done(ok);
    chk("R3 first word", wfirst, 32'hA0000001);
    chk("R3 last word", wlast, 32'hA0000005);

    launch(24'h000640);
    chk("R8 busy after start", {31'd0, busy}, 32'd1);
    repeat (5) @(negedge clk);
    start = 1'b1; start_addr = 24'h000100;
    @(negedge clk); start = 1'b0;
    wait_done(ok);
    chk("R8 start ignored total", cycle_total, 32'd350);
    chk("R8 start ignored loop", {31'd0, loop_err}, 32'd1);

    repeat (20) @(negedge clk);
    chk("R9 loop held", {31'd0, loop_err}, 32'd1);
    chk("R5 total held", cycle_total, 32'd350);
    launch(24'h000100);
    chk("R9 loop cleared on start", {31'd0, loop_err}, 32'd0);
    wait_done(ok);
    chk("R9 loop after clean walk", {31'd0, loop_err}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule